// File: doc/BRIEF.md
# Video Register Write Latch

This block is the processor-facing write side of a tile-based video controller. It decodes byte writes to eight register slots. From them it keeps a 15-bit temporary address, a 15-bit current address, a 3-bit fine horizontal scroll, and one first/second toggle that the scroll and address slots share. Scroll and address writes come in pairs, and each write of a pair splices its own bit fields into the temporary address. The second address write then moves the whole temporary address into the current address.

A write to the data slot goes to palette storage or to external video memory, chosen by the current address, and then moves the current address on by 1 or 32. Palette storage is 32 six-bit entries. A write to a backdrop entry is copied to every backdrop position. Video memory writes leave the block as a one-cycle strobe that carries a 14-bit address and a data byte. Sprite memory writes leave the same way, with the address taken from an internal pointer. A control write that turns on the interrupt enable while vertical blank is active raises a one-cycle interrupt request.

Top module: `vrl_top`

## Requirements
- R1: A write to slot 0 (control) puts data bits 1:0 into temporary address bits 11:10 and leaves every other temporary bit unchanged.
- R2: `nmi_req` pulses high for exactly one cycle after a control write only when data bit 7 is 1, the previously stored control bit 7 is 0, and `vblank_in` is 1. In every other case it stays low.
- R3: A slot 5 (scroll) write with the toggle at 0 puts data bits 7:3 into temporary bits 4:0 and data bits 2:0 into `fine_x`.
- R4: A scroll write with the toggle at 1 puts data bits 7:3 into temporary bits 9:5 and data bits 2:0 into temporary bits 14:12.
- R5: A slot 6 (address) write with the toggle at 0 puts data bits 5:0 into temporary bits 13:8 and clears bit 14. With the toggle at 1 it puts the data into temporary bits 7:0 and copies the resulting temporary address into the current address.
- R6: Scroll and address writes each invert the one shared toggle. Writes to other slots leave it unchanged.
- R7: A slot 7 (data port) write whose 14-bit current address is below 0x3F00 produces a `vram_we` pulse in the following cycle, carrying that address and the data. Every data port write then adds 32 to the current address if control bit 2 is set, and adds 1 if it is not.
- R8: Data port addresses from 0x3000 to 0x3EFF go out with address bit 12 cleared.
- R9: Data port addresses at or above 0x3F00 produce no `vram_we`. They write data bits 5:0 into palette entry {addr[4], addr[3:0]}, where entries 0 to 15 are background and 16 to 31 are sprite. `pal_rd_idx` selects which entry `pal_rd_data` shows.
- R10: A palette write whose address bits 3:0 are 0 writes both entry 0 and entry 16. After every palette write, entries 4, 8, 12, 16, 20, 24 and 28 all equal entry 0.
- R11: A slot 3 write loads the sprite pointer. A slot 4 write produces a `spr_we` pulse in the next cycle at the pointer with the data, then adds 1 to the pointer, wrapping from 255 to 0.
- R12: Writes to slot 2 (status) and slot 1 change no address, toggle, scroll, pointer, palette or strobe output.
- R13: After reset, both addresses, `fine_x`, the toggle, all palette entries and every strobe output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write this cycle |
| wr_sel | input | 3 | Register slot being written |
| wr_data | input | 8 | Write data byte |
| vblank_in | input | 1 | Vertical-blank status bit |
| pal_rd_idx | input | 5 | Palette entry to observe |
| nmi_req | output | 1 | One-cycle interrupt request |
| tmp_addr | output | 15 | Temporary address |
| cur_addr | output | 15 | Current address |
| fine_x | output | 3 | Fine horizontal scroll |
| wr_toggle | output | 1 | Shared first/second write toggle |
| vram_we | output | 1 | Video memory write strobe |
| vram_addr | output | 14 | Video memory write address |
| vram_wdata | output | 8 | Video memory write data |
| spr_we | output | 1 | Sprite memory write strobe |
| spr_addr | output | 8 | Sprite memory write address |
| spr_wdata | output | 8 | Sprite memory write data |
| pal_rd_data | output | 6 | Selected palette entry |

## Verification
The bench interleaves scroll and address writes so that they share the toggle. A design with two separate toggles would then splice fields into the wrong half of the temporary address. Addresses 0x3EFF and 0x3F00 check the fold-versus-palette boundary, where a bad comparison would leak a strobe or fold the wrong address. A write to sprite palette position 4 must be overwritten by the backdrop copy, and a write at 0x3F10 must reach entry 0. The sprite pointer is walked across 255 to check its wrap. The interrupt is tried with vertical blank off and with the enable already set, where a level-sensitive design would fire when it should not.

// File: rtl/vrl_pkg.sv
package vrl_pkg;
  localparam int ADDR_W   = 15;
  localparam int PORT_W   = 14;
  localparam int DATA_W   = 8;
  localparam int FINE_W   = 3;
  localparam int PAL_W    = 6;
  localparam int PAL_N    = 32;
  localparam int SPR_AW   = 8;

  localparam logic [PORT_W-1:0] PAL_BASE  = 14'h3F00;
  localparam logic [PORT_W-1:0] FOLD_BASE = 14'h3000;

  typedef enum logic [2:0] {
    SEL_CONTROL = 3'd0,
    SEL_MODE    = 3'd1,
    SEL_STATUS  = 3'd2,
    SEL_SPRPTR  = 3'd3,
    SEL_SPRDAT  = 3'd4,
    SEL_SCROLL  = 3'd5,
    SEL_VADDR   = 3'd6,
    SEL_PORT    = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/vrl_rst_sync.sv
module vrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vrl_addr_regs.sv
module vrl_addr_regs
  import vrl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int FW = FINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_scroll,
  input  logic          wr_vaddr,
  input  logic          wr_port,
  input  logic [DW-1:0] din,
  input  logic          vblank,
  output logic [AW-1:0] tmp_q,
  output logic [AW-1:0] cur_q,
  output logic [FW-1:0] finex_q,
  output logic          tog_q,
  output logic          nmi_q
);
  localparam logic [AW-1:0] STEP_ROW = AW'(32);
  localparam logic [AW-1:0] STEP_ONE = AW'(1);

  logic          inc32_q, nmien_q;
  logic [AW-1:0] tmp_d, cur_d;
  logic [FW-1:0] finex_d;
  logic          tog_d, inc32_d, nmien_d, nmi_d, upd_en;

  assign upd_en = wr_ctrl | wr_scroll | wr_vaddr | wr_port;

  always_comb begin
    tmp_d   = tmp_q;
    cur_d   = cur_q;
    finex_d = finex_q;
    tog_d   = tog_q;
    inc32_d = inc32_q;
    nmien_d = nmien_q;
    nmi_d   = 1'b0;
    if (wr_ctrl) begin
      tmp_d[11:10] = din[1:0];
      inc32_d      = din[2];
      nmien_d      = din[7];
      nmi_d        = din[7] & ~nmien_q & vblank;
    end
    if (wr_scroll) begin
      if (!tog_q) begin
        tmp_d[4:0] = din[7:3];
        finex_d    = din[2:0];
      end else begin
        tmp_d[9:5]   = din[7:3];
        tmp_d[14:12] = din[2:0];
      end
      tog_d = ~tog_q;
    end
    if (wr_vaddr) begin
      if (!tog_q) begin
        tmp_d[13:8] = din[5:0];
        tmp_d[14]   = 1'b0;
      end else begin
        tmp_d[7:0] = din;
        cur_d      = {tmp_q[14:8], din};
      end
      tog_d = ~tog_q;
    end
    if (wr_port) begin
      cur_d = cur_q + (inc32_q ? STEP_ROW : STEP_ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q   <= '0;
      cur_q   <= '0;
      finex_q <= '0;
      tog_q   <= 1'b0;
      inc32_q <= 1'b0;
      nmien_q <= 1'b0;
      nmi_q   <= 1'b0;
    end else begin
      nmi_q <= nmi_d;
      if (upd_en) begin
        tmp_q   <= tmp_d;
        cur_q   <= cur_d;
        finex_q <= finex_d;
        tog_q   <= tog_d;
        inc32_q <= inc32_d;
        nmien_q <= nmien_d;
      end
    end
  end

  a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_scroll || wr_vaddr) |=> (tog_q != $past(tog_q)));
  a_r6_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl || wr_port) |=> $stable(tog_q));
  a_r5_copy_to_cur: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vaddr && tog_q) |=> (cur_q == tmp_q));
  a_r2_nmi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> $past(wr_ctrl && vblank && din[7]));
  a_r7_port_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> ((cur_q == $past(cur_q) + STEP_ONE) || (cur_q == $past(cur_q) + STEP_ROW)));
endmodule

// File: rtl/vrl_palette.sv
module vrl_palette
  import vrl_pkg::*;
#(
  parameter int PW = PAL_W,
  parameter int PN = PAL_N
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [$clog2(PN)-1:0] idx,
  input  logic [PW-1:0]         wdata,
  input  logic [$clog2(PN)-1:0] rd_idx,
  output logic [PW-1:0]         rd_data
);
  localparam int HALF   = PN / 2;
  localparam int STRIDE = 4;
  localparam int IW     = $clog2(PN);

  logic [PW-1:0] mem_q [PN];
  logic [PW-1:0] mem_d [PN];

  always_comb begin
    for (int i = 0; i < PN; i++) mem_d[i] = mem_q[i];
    if (idx[IW-2:0] == '0) begin
      mem_d[0]    = wdata;
      mem_d[HALF] = wdata;
    end else begin
      mem_d[idx] = wdata;
    end
    for (int k = 0; k < HALF; k += STRIDE) begin
      mem_d[k]        = mem_d[0];
      mem_d[HALF + k] = mem_d[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PN; i++) mem_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < PN; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = mem_q[rd_idx];

  a_r10_backdrop_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_q[4] == mem_q[0]) && (mem_q[12] == mem_q[0]) &&
    (mem_q[HALF] == mem_q[0]) && (mem_q[HALF + 8] == mem_q[0]));
  a_r9_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx[1:0] != 2'b00) |=> (mem_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/vrl_sprite_ptr.sv
module vrl_sprite_ptr
  import vrl_pkg::*;
#(
  parameter int SW = SPR_AW,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ptr,
  input  logic          wr_dat,
  input  logic [DW-1:0] din,
  output logic          we_q,
  output logic [SW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  logic [SW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_ptr) ptr_d = din[SW-1:0];
    if (wr_dat) ptr_d = ptr_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= wr_dat;
      if (wr_ptr || wr_dat) ptr_q <= ptr_d;
      if (wr_dat) begin
        addr_q  <= ptr_q;
        wdata_q <= din;
      end
    end
  end

  a_r11_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (ptr_q == $past(ptr_q) + SW'(1)));
  a_r11_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(wr_dat));
endmodule

// File: rtl/vrl_top.sv
module vrl_top
  import vrl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              wr_sel,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    vblank_in,
  input  logic [$clog2(PAL_N)-1:0] pal_rd_idx,
  output logic                    nmi_req,
  output logic [ADDR_W-1:0]       tmp_addr,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic [FINE_W-1:0]       fine_x,
  output logic                    wr_toggle,
  output logic                    vram_we,
  output logic [PORT_W-1:0]       vram_addr,
  output logic [DATA_W-1:0]       vram_wdata,
  output logic                    spr_we,
  output logic [SPR_AW-1:0]       spr_addr,
  output logic [DATA_W-1:0]       spr_wdata,
  output logic [PAL_W-1:0]        pal_rd_data
);
  localparam int PIW = $clog2(PAL_N);

  logic rst_s_n;
  logic wr_ctrl, wr_scroll, wr_vaddr, wr_port, wr_sptr, wr_sdat;
  logic [PORT_W-1:0] port_a, fold_a;
  logic is_pal, pal_we, vram_we_d;

  vrl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  always_comb begin
    wr_ctrl   = wr_en && (wr_sel == SEL_CONTROL);
    wr_scroll = wr_en && (wr_sel == SEL_SCROLL);
    wr_vaddr  = wr_en && (wr_sel == SEL_VADDR);
    wr_port   = wr_en && (wr_sel == SEL_PORT);
    wr_sptr   = wr_en && (wr_sel == SEL_SPRPTR);
    wr_sdat   = wr_en && (wr_sel == SEL_SPRDAT);
  end

  vrl_addr_regs u_addr (
    .clk(clk), .rst_n(rst_s_n),
    .wr_ctrl(wr_ctrl), .wr_scroll(wr_scroll), .wr_vaddr(wr_vaddr), .wr_port(wr_port),
    .din(wr_data), .vblank(vblank_in),
    .tmp_q(tmp_addr), .cur_q(cur_addr), .finex_q(fine_x), .tog_q(wr_toggle),
    .nmi_q(nmi_req)
  );

  always_comb begin
    port_a = cur_addr[PORT_W-1:0];
    is_pal = (port_a >= PAL_BASE);
    fold_a = port_a;
    if (!is_pal && (port_a >= FOLD_BASE)) fold_a[12] = 1'b0;
    pal_we    = wr_port && is_pal;
    vram_we_d = wr_port && !is_pal;
  end

  vrl_palette u_pal (
    .clk(clk), .rst_n(rst_s_n), .we(pal_we),
    .idx(port_a[PIW-1:0]), .wdata(wr_data[PAL_W-1:0]),
    .rd_idx(pal_rd_idx), .rd_data(pal_rd_data)
  );

  vrl_sprite_ptr u_spr (
    .clk(clk), .rst_n(rst_s_n), .wr_ptr(wr_sptr), .wr_dat(wr_sdat), .din(wr_data),
    .we_q(spr_we), .addr_q(spr_addr), .wdata_q(spr_wdata)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vram_we    <= 1'b0;
      vram_addr  <= '0;
      vram_wdata <= '0;
    end else begin
      vram_we <= vram_we_d;
      if (vram_we_d) begin
        vram_addr  <= fold_a;
        vram_wdata <= wr_data;
      end
    end
  end

  a_r8_fold_window_empty: assert property (@(posedge clk) disable iff (!rst_s_n)
    vram_we |-> (vram_addr[13:12] != 2'b11));
  a_r9_palette_no_strobe: assert property (@(posedge clk) disable iff (!rst_s_n)
    vram_we |-> ($past(wr_port) && ($past(cur_addr[PORT_W-1:0]) < PAL_BASE)));
endmodule

// File: tb/vrl_top_tb_top.sv
`timescale 1ns/1ps
module vrl_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic vblank_in;
  logic [4:0] pal_rd_idx;
  logic nmi_req, wr_toggle, vram_we, spr_we;
  logic [14:0] tmp_addr, cur_addr;
  logic [2:0] fine_x;
  logic [13:0] vram_addr;
  logic [7:0] vram_wdata, spr_wdata, spr_addr;
  logic [5:0] pal_rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [21:0] vram_exp[$];
  logic [15:0] spr_exp[$];

  always #4 clk = ~clk;

  vrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vblank_in(vblank_in), .pal_rd_idx(pal_rd_idx), .nmi_req(nmi_req),
    .tmp_addr(tmp_addr), .cur_addr(cur_addr), .fine_x(fine_x), .wr_toggle(wr_toggle),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata), .pal_rd_data(pal_rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic port_vram(input logic [7:0] d, input logic [13:0] exp_a);
    vram_exp.push_back({exp_a, d});
    wr(3'd7, d);
  endtask

  task automatic spr_write(input logic [7:0] d, input logic [7:0] exp_a);
    spr_exp.push_back({exp_a, d});
    wr(3'd4, d);
  endtask

  task automatic pal_chk(input string tag, input logic [4:0] idx, input logic [5:0] exp);
    pal_rd_idx = idx;
    #1;
    chk(tag, {26'd0, pal_rd_data}, {26'd0, exp});
  endtask

  // monitor: compares strobes against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && vram_we) begin
      if (vram_exp.size() == 0) chk("R9 unexpected vram strobe", {10'd0, vram_addr, vram_wdata}, 32'hFFFF_FFFF);
      else chk("R7 vram strobe", {10'd0, vram_addr, vram_wdata}, {10'd0, vram_exp.pop_front()});
    end
    if (rst_n && spr_we) begin
      if (spr_exp.size() == 0) chk("R11 unexpected sprite strobe", {16'd0, spr_addr, spr_wdata}, 32'hFFFF_FFFF);
      else chk("R11 sprite strobe", {16'd0, spr_addr, spr_wdata}, {16'd0, spr_exp.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'd0; vblank_in = 1'b0; pal_rd_idx = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state
    chk("R13 tmp", {17'd0, tmp_addr}, 32'd0);
    chk("R13 cur", {17'd0, cur_addr}, 32'd0);
    chk("R13 finex/toggle/nmi", {28'd0, fine_x, wr_toggle}, 32'd0);
    chk("R13 strobes", {29'd0, nmi_req, vram_we, spr_we}, 32'd0);
    pal_chk("R13 palette", 5'd7, 6'd0);

    // R1 control nametable bits
    wr(3'd0, 8'h03);
    chk("R1 tmp after control", {17'd0, tmp_addr}, 32'h0C00);
    // R3 first scroll
    wr(3'd5, 8'h7D);
    chk("R3 tmp", {17'd0, tmp_addr}, 32'h0C0F);
    chk("R3 finex", {29'd0, fine_x}, 32'd5);
    chk("R6 toggle set", {31'd0, wr_toggle}, 32'd1);
    // R4 second scroll
    wr(3'd5, 8'h5E);
    chk("R4 tmp", {17'd0, tmp_addr}, 32'h6D6F);
    chk("R6 toggle clear", {31'd0, wr_toggle}, 32'd0);
    // R12 status and slot 1 ignored
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hFF);
    chk("R12 tmp kept", {17'd0, tmp_addr}, 32'h6D6F);
    chk("R12 toggle/finex kept", {28'd0, fine_x, wr_toggle}, 32'h0A);
    chk("R12 cur kept", {17'd0, cur_addr}, 32'd0);
    // R5 address pair, masking and bit 14 clear
    wr(3'd6, 8'hE0);
    chk("R5 first address", {17'd0, tmp_addr}, 32'h206F);
    chk("R5 cur untouched", {17'd0, cur_addr}, 32'd0);
    wr(3'd6, 8'h05);
    chk("R5 second address cur", {17'd0, cur_addr}, 32'h2005);
    // R6 shared toggle: scroll then address
    wr(3'd5, 8'h08);
    chk("R6 shared toggle", {31'd0, wr_toggle}, 32'd1);
    wr(3'd6, 8'h44);
    chk("R6 address as second write", {17'd0, cur_addr}, 32'h2044);
    // R7 increments
    port_vram(8'hA5, 14'h2044);
    port_vram(8'h5A, 14'h2045);
    chk("R7 inc by 1", {17'd0, cur_addr}, 32'h2046);
    wr(3'd0, 8'h04);
    port_vram(8'h11, 14'h2046);
    chk("R7 inc by 32", {17'd0, cur_addr}, 32'h2066);
    // R8 fold
    wr(3'd6, 8'h35); wr(3'd6, 8'h40);
    port_vram(8'h77, 14'h2540);
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h3E); wr(3'd6, 8'hFF);
    port_vram(8'h01, 14'h2EFF);
    chk("R8 cur at palette base", {17'd0, cur_addr}, 32'h3F00);
    // R9/R10 palette
    wr(3'd7, 8'hFF);
    pal_chk("R10 bg0", 5'd0, 6'h3F);
    pal_chk("R10 sp0", 5'd16, 6'h3F);
    pal_chk("R10 bg4", 5'd4, 6'h3F);
    pal_chk("R10 sp12", 5'd28, 6'h3F);
    wr(3'd7, 8'hEA);
    pal_chk("R9 bg1 masked", 5'd1, 6'h2A);
    pal_chk("R9 sp1 untouched", 5'd17, 6'h00);
    wr(3'd6, 8'h3F); wr(3'd6, 8'h14);
    wr(3'd7, 8'h15);
    wr(3'd7, 8'h33);
    pal_chk("R10 sp4 overridden", 5'd20, 6'h3F);
    pal_chk("R9 sp5", 5'd21, 6'h33);
    wr(3'd6, 8'h3F); wr(3'd6, 8'h10);
    wr(3'd7, 8'h0C);
    pal_chk("R10 0x3F10 to bg0", 5'd0, 6'h0C);
    pal_chk("R10 bg8 follows", 5'd8, 6'h0C);
    pal_chk("R9 bg1 kept", 5'd1, 6'h2A);
    // R11 sprite pointer
    wr(3'd3, 8'hFE);
    spr_write(8'h11, 8'hFE);
    spr_write(8'h22, 8'hFF);
    spr_write(8'h33, 8'h00);
    // R2 interrupt
    vblank_in = 1'b0;
    wr(3'd0, 8'h80);
    chk("R2 no nmi without vblank", {31'd0, nmi_req}, 32'd0);
    vblank_in = 1'b1;
    wr(3'd0, 8'h80);
    chk("R2 no nmi when already enabled", {31'd0, nmi_req}, 32'd0);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h80);
    chk("R2 nmi pulse", {31'd0, nmi_req}, 32'd1);
    @(negedge clk);
    chk("R2 nmi one cycle", {31'd0, nmi_req}, 32'd0);
    vblank_in = 1'b0;

    repeat (3) @(negedge clk);
    chk("R7 vram queue drained", vram_exp.size(), 32'd0);
    chk("R11 sprite queue drained", spr_exp.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule